// File: doc/BRIEF.md
# Flash Embedded-Operation Status Read Generator

This block decides what a host sees when it reads a flash device while a byte program or a sector erase runs in the background, or while an erase is held in suspend. For each read it returns either the ordinary array byte or a status byte. The status byte has a polling bit, two toggle bits, a failure bit and a bit that shows whether the window for adding sectors to an erase has closed. The block also drives the open-drain ready/busy line. The command decoder supplies the operation state, the polled data bit, the sectors selected for erase and the two flags. The array supplies the data byte for the address being read.

The two toggle bits move independently. The operation toggle inverts on every read while the device is actually busy. The sector toggle inverts only on reads that land in a sector chosen for erase, and it keeps doing so during suspend. Polling both bits tells the host whether an erase is running or suspended, and which sectors it covers.

Top module: `flash_status_gen`

## Requirements
- R1: The operation code `op_i` is 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend; codes 5 to 7 count as idle. When idle, `rd_data_o` equals `array_data_i`.
- R2: In program (1) and program during suspend (4), every read returns a status byte whose bit 7 is the inverse of `prog_msb_i`.
- R3: In erase (2), every read returns a status byte whose bit 7 is 0.
- R4: Bit 6 of the status byte is the operation toggle. It is 0 after reset. It inverts after each completed read while the code is 1, 2 or 4, at any address, and otherwise holds its value.
- R5: Bit 2 of the status byte is the sector toggle. It is 0 after reset. It inverts after each completed read whose sector `rd_sector_i` has its bit set in `erase_mask_i` while the code is 2, 3 or 4, and otherwise holds its value.
- R6: In erase suspended (3), a read of a selected sector returns a status byte with bit 7 = 1 and bit 6 unchanged between reads. A read of any other sector returns `array_data_i`.
- R7: In every status byte, bit 5 equals `fail_i`, bit 3 equals `window_closed_i`, and bits 4, 1 and 0 are 0.
- R8: `busy_pull_o` is 1 (the line is pulled low) while the code is 1, 2 or 4. It is 0 when the code is 0, 3 or 5 to 7, and out of reset.
- R9: A read is complete at the first clock edge that samples `rd_strobe_i` low after sampling it high. The toggles advance on that edge, so two back-to-back reads during an active operation differ in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation state code |
| prog_msb_i | input | 1 | Bit 7 of the byte being programmed |
| erase_mask_i | input | 2**SEC_W | One bit per sector, set when the sector is selected for erase |
| rd_sector_i | input | SEC_W | Sector field of the read address |
| rd_strobe_i | input | 1 | Read strobe, high for the duration of a read |
| array_data_i | input | 8 | Array byte at the read address |
| fail_i | input | 1 | Operation exceeded its internal limit |
| window_closed_i | input | 1 | Window for adding erase sectors has expired |
| rd_data_o | output | 8 | Byte returned to the host |
| busy_pull_o | output | 1 | Pull-down enable of the open-drain ready/busy line |

## Verification
The read byte is combinational: it is due in the same cycle as the strobe and reflects the toggle values left by the previous read. The toggles advance at the second clock edge of a read, the first edge that samples the strobe low after the strobe went high. The driver therefore raises the strobe for exactly one cycle and pushes the expected byte when it does so. The monitor pops and compares that byte at the falling clock edge inside the strobe cycle. The busy output is combinational from the operation code and is checked half a cycle after each code change.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_ESUSP = 3'd3,
    OP_SPROG = 3'd4
  } op_e;

  // bit order is host-visible
  typedef struct packed {
    logic       poll;
    logic       tog_any;
    logic       fail;
    logic       rsvd4;
    logic       win;
    logic       tog_sec;
    logic [1:0] rsvd;
  } status_t;

  function automatic logic op_busy(op_e op);
    return (op == OP_PROG) || (op == OP_ERASE) || (op == OP_SPROG);
  endfunction

  function automatic logic op_erase_ctx(op_e op);
    return (op == OP_ERASE) || (op == OP_ESUSP) || (op == OP_SPROG);
  endfunction
endpackage

// File: rtl/flash_status_sector_sel.sv
module flash_status_sector_sel #(
  parameter int SEC_W = 4,
  localparam int NSEC = 1 << SEC_W
) (
  input  logic [NSEC-1:0]  mask_i,
  input  logic [SEC_W-1:0] sector_i,
  output logic             hit_o
);
  assign hit_o = mask_i[sector_i];
endmodule

// File: rtl/flash_status_toggle.sv
module flash_status_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (adv_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/flash_status_compose.sv
module flash_status_compose
  import flash_status_pkg::*;
(
  input  op_e        op_i,
  input  logic       hit_i,
  input  logic       prog_msb_i,
  input  logic       tog_any_i,
  input  logic       tog_sec_i,
  input  logic       fail_i,
  input  logic       win_i,
  input  logic [7:0] array_i,
  output logic [7:0] data_o
);
  status_t st;

  always_comb begin
    st         = '0;
    st.tog_any = tog_any_i;
    st.fail    = fail_i;
    st.win     = win_i;
    st.tog_sec = tog_sec_i;
    data_o     = array_i;
    unique case (op_i)
      OP_PROG, OP_SPROG: begin
        st.poll = ~prog_msb_i;
        data_o  = st;
      end
      OP_ERASE: begin
        st.poll = 1'b0;
        data_o  = st;
      end
      OP_ESUSP: begin
        st.poll = 1'b1;
        if (hit_i) data_o = st;
      end
      default: data_o = array_i;
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int SEC_W = 4,
  localparam int NSEC = 1 << SEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic             prog_msb_i,
  input  logic [NSEC-1:0]  erase_mask_i,
  input  logic [SEC_W-1:0] rd_sector_i,
  input  logic             rd_strobe_i,
  input  logic [7:0]       array_data_i,
  input  logic             fail_i,
  input  logic             window_closed_i,
  output logic [7:0]       rd_data_o,
  output logic             busy_pull_o
);
  localparam int NTOG = 2;

  op_e  op;
  logic sector_hit;
  logic strobe_q, qual_any_q, qual_sec_q, rd_done;
  logic [NTOG-1:0] tog_adv, tog_q;

  assign op = op_e'(op_i);

  flash_status_sector_sel #(.SEC_W(SEC_W)) u_sel (
    .mask_i   (erase_mask_i),
    .sector_i (rd_sector_i),
    .hit_o    (sector_hit)
  );

  // qualifiers captured while the strobe is high, applied at its trailing edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q   <= 1'b0;
      qual_any_q <= 1'b0;
      qual_sec_q <= 1'b0;
    end else begin
      strobe_q <= rd_strobe_i;
      if (rd_strobe_i) begin
        qual_any_q <= op_busy(op);
        qual_sec_q <= sector_hit && op_erase_ctx(op);
      end
    end
  end

  assign rd_done    = strobe_q && !rd_strobe_i;
  assign tog_adv[0] = rd_done && qual_any_q;
  assign tog_adv[1] = rd_done && qual_sec_q;

  for (genvar g = 0; g < NTOG; g++) begin : g_tog
    flash_status_toggle u_tog (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (tog_adv[g]),
      .q_o    (tog_q[g])
    );
  end

  flash_status_compose u_cmp (
    .op_i       (op),
    .hit_i      (sector_hit),
    .prog_msb_i (prog_msb_i),
    .tog_any_i  (tog_q[0]),
    .tog_sec_i  (tog_q[1]),
    .fail_i     (fail_i),
    .win_i      (window_closed_i),
    .array_i    (array_data_i),
    .data_o     (rd_data_o)
  );

  assign busy_pull_o = op_busy(op);

  AST_TOG_ANY_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_q && !rd_strobe_i && qual_any_q) |=> (tog_q[0] != $past(tog_q[0]))); // R4
  AST_TOG_ANY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_q && !rd_strobe_i && qual_any_q) |=> $stable(tog_q[0])); // R4
  AST_TOG_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_q && !rd_strobe_i && qual_sec_q) |=> $stable(tog_q[1])); // R5
  AST_ERASE_POLL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ERASE) |-> !rd_data_o[7]); // R3
  AST_SUSP_HIT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ESUSP && sector_hit) |-> (rd_data_o[7] && !busy_pull_o)); // R6
endmodule

// File: tb/flash_status_gen_test.sv
`timescale 1ns/1ps
module flash_status_gen_test;
  localparam int SEC_W = 4;
  localparam int NSEC  = 1 << SEC_W;
  localparam time CLK_T = 20ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       op = 3'd0;
  logic             prog_msb = 1'b0;
  logic [NSEC-1:0]  mask = '0;
  logic [SEC_W-1:0] sector = '0;
  logic             strobe = 1'b0;
  logic [7:0]       array_data;
  logic             fail = 1'b0;
  logic             win = 1'b0;
  logic [7:0]       rd_data;
  logic             busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit m_any = 1'b0;
  bit m_sec = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_T/2) clk = ~clk;

  assign array_data = {sector, ~sector} ^ 8'h3C;

  flash_status_gen #(.SEC_W(SEC_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .prog_msb_i(prog_msb),
    .erase_mask_i(mask), .rd_sector_i(sector), .rd_strobe_i(strobe),
    .array_data_i(array_data), .fail_i(fail), .window_closed_i(win),
    .rd_data_o(rd_data), .busy_pull_o(busy)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [SEC_W-1:0] s);
    logic hit = mask[s];
    logic [7:0] st = {1'b0, m_any, fail, 1'b0, win, m_sec, 2'b00};
    logic [7:0] arr = {s, ~s} ^ 8'h3C;
    case (op)
      3'd1, 3'd4: return {~prog_msb, st[6:0]};
      3'd2:       return st;
      3'd3:       return hit ? {1'b1, st[6:0]} : arr;
      default:    return arr;
    endcase
  endfunction

  // driver: one-cycle strobe, expected byte pushed to the scoreboard
  task automatic rd(input logic [SEC_W-1:0] s, input string tag);
    @(posedge clk); #1;
    sector = s;
    exp_q.push_back(model(s));
    tag_q.push_back(tag);
    if (op == 3'd1 || op == 3'd2 || op == 3'd4) m_any = ~m_any;
    if (mask[s] && (op == 3'd2 || op == 3'd3 || op == 3'd4)) m_sec = ~m_sec;
    strobe = 1'b1;
    @(posedge clk); #1;
    strobe = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic chk_busy(input logic exp, input string tag);
    @(negedge clk);
    check(tag, {7'd0, busy}, {7'd0, exp});
  endtask

  // monitor
  always @(negedge clk) begin
    if (strobe) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: actual read with empty scoreboard expected none");
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_busy(1'b0, "R8 reset");
    rd(4'd3, "R1 idle array");
    rd(4'd9, "R1 idle array");
    // program
    op = 3'd1; prog_msb = 1'b1;
    chk_busy(1'b1, "R8 program busy");
    rd(4'd1, "R2 R4 program first");
    rd(4'd1, "R4 R9 program second");
    prog_msb = 1'b0;
    rd(4'd12, "R2 program msb0");
    fail = 1'b1;
    rd(4'd0, "R7 fail bit");
    fail = 1'b0;
    op = 3'd0;
    chk_busy(1'b0, "R8 idle after program");
    rd(4'd1, "R1 done array");
    // erase of sectors 2 and 5
    mask = '0; mask[2] = 1'b1; mask[5] = 1'b1;
    op = 3'd2;
    rd(4'd2, "R3 R5 erase hit");
    rd(4'd7, "R3 R5 erase miss");
    win = 1'b1;
    rd(4'd5, "R7 window bit");
    rd(4'd5, "R5 erase hit again");
    // suspend
    op = 3'd3;
    chk_busy(1'b0, "R8 suspended ready");
    rd(4'd2, "R6 susp hit");
    rd(4'd2, "R6 R5 susp hit steady");
    rd(4'd7, "R6 susp miss array");
    // program during suspend
    op = 3'd4; prog_msb = 1'b1;
    chk_busy(1'b1, "R8 susp program busy");
    rd(4'd9, "R2 R4 susp program");
    rd(4'd5, "R5 susp program hit");
    // reserved code
    op = 3'd6;
    chk_busy(1'b0, "R8 reserved code");
    rd(4'd5, "R1 reserved code array");
    op = 3'd0; win = 1'b0;
    rd(4'd4, "R1 final idle");
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R9: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule